// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block is the architectural register storage for a load/store processor in which memory traffic is never a separate instruction. It holds three files of eight entries each: address registers (18 bits), index registers (18 bits) and operand registers (60 bits). Software moves data between memory and the operand registers by writing an address register. For some address registers that write fetches the word at the new address into the operand register with the same number. For others it stores the operand register with the same number to the new address.

The execute stage uses one write port and one combinational read port. Each port selects a file with a 2-bit code: 0 selects address, 1 selects index, 2 selects operand, and 3 selects nothing. Memory is reached through a single request/acknowledge port with an 18-bit word address and 60-bit data. Only one request is in flight at a time. A busy scoreboard output marks the operand register waiting for load data. While that bit is set, reads of that register are flagged not valid and writes to it are held off.

Top module: `addr_trig_regfile`

## Requirements
- R1: After reset every register in all three files reads zero, `mem_req` is low, `busy_mask` is zero and `wr_ready` is high.
- R2: A write to address register 0 stores the low 18 bits of `wr_data` and starts no memory request.
- R3: A write accepted to address register 1 to 5 raises `mem_req` with `mem_we` low and `mem_addr` equal to the low 18 bits written, in the cycle after acceptance. The request and its fields stay unchanged until `mem_ack`. The `mem_rdata` sampled with the acknowledge lands in the operand register with the same number.
- R4: From the cycle after a load is triggered until the cycle after its acknowledge, exactly that operand register's bit of `busy_mask` is 1. Reading that register in this window gives `rd_valid` low.
- R5: A write accepted to address register 6 or 7 raises `mem_req` with `mem_we` high, `mem_addr` equal to the written address, and `mem_wdata` equal to the same-numbered operand register.
- R6: Store data is taken when the address register is written. Writing that operand register while the store is pending leaves `mem_wdata` unchanged.
- R7: While a request is outstanding, a write to address register 1 to 7 drives `wr_ready` low and is not applied. Writes to address register 0 and to the index file still proceed.
- R8: Index register 0 always reads zero, and writes to it are ignored.
- R9: Index registers 1 to 7 and all operand registers read back what was last written to them. Index registers keep the low 18 bits. Address and index values are zero-extended on `rd_data`.
- R10: A write to an operand register whose busy bit is set drives `wr_ready` low and is not applied.
- R11: File code 3 reads as zero, and writes with it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request from execute |
| wr_file | input | 2 | File select for write (0 addr, 1 index, 2 operand, 3 none) |
| wr_idx | input | 3 | Register number for write |
| wr_data | input | 60 | Write data (low 18 bits used for addr/index) |
| wr_ready | output | 1 | Write accepted this cycle when high |
| rd_file | input | 2 | File select for read |
| rd_idx | input | 3 | Register number for read |
| rd_data | output | 60 | Read data, zero-extended |
| rd_valid | output | 1 | Low when reading an operand register awaiting load data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | 18 | Word address |
| mem_wdata | output | 60 | Store data |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | 60 | Load data, sampled with `mem_ack` |
| busy_mask | output | 8 | One bit per operand register awaiting load data |

## Verification
The bench loops over every address register number with all-zeros, all-ones, alternating-bit and mixed addresses. This shows that numbers 1 to 5 load, 6 and 7 store, and 0 stays quiet, and that the returned word reaches the matching operand register and no other. The acknowledge latency is varied so that a request dropped early or a scoreboard cleared too soon is caught. Each file is swept with index-dependent patterns, which exposes crossed indices, the hard zero, and truncation of the 18-bit files. Writes attempted while a request is pending cover the stall paths: triggering address writes, operand writes that would hit a busy register, and an operand write during a store that must not reach the captured data.

// File: rtl/art_pkg.sv
// Package: shared sizes, file-select encoding and the pairing ranges that
// decide which address registers trigger loads and which trigger stores.
// Assumes the load and store ranges do not overlap and exclude register 0.
package art_pkg;
    localparam int ADDR_W      = 18;
    localparam int DATA_W      = 60;
    localparam int NUM_REGS    = 8;
    localparam int LOAD_FIRST  = 1;
    localparam int LOAD_LAST   = 5;
    localparam int STORE_FIRST = 6;
    localparam int STORE_LAST  = 7;

    typedef enum logic [1:0] {
        FILE_A    = 2'd0,
        FILE_B    = 2'd1,
        FILE_X    = 2'd2,
        FILE_NONE = 2'd3
    } file_sel_e;
endpackage

// File: rtl/art_reg_bank.sv
// Register bank: N entries of W bits, one port write plus one fill write
// (fill wins on the same entry). HARD_ZERO0 makes entry 0 a constant zero.
// Assumes the owner resolves stalls; every enable presented here is applied.
module art_reg_bank #(
    parameter int W          = 18,
    parameter int N          = 8,
    parameter bit HARD_ZERO0 = 1'b0,
    localparam int IW        = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_data,
    input  logic                fill_en,
    input  logic [IW-1:0]       fill_idx,
    input  logic [W-1:0]        fill_data,
    output logic [N-1:0][W-1:0] regs_o
);
    for (genvar i = 0; i < N; i++) begin : g_entry
        if (i == 0 && HARD_ZERO0) begin : g_zero
            assign regs_o[i] = '0;
        end else begin : g_store
            logic [W-1:0] val_q;
            // Entry update: reset, memory fill, or port write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (fill_en && fill_idx == IW'(i))
                    val_q <= fill_data;
                else if (wr_en && wr_idx == IW'(i))
                    val_q <= wr_data;
            end
            assign regs_o[i] = val_q;
        end
    end

    if (HARD_ZERO0) begin : g_zchk
        // Entry 0 never leaves zero once reset has run.
        assert_b0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            regs_o[0] == '0);
    end
endmodule

// File: rtl/art_mem_seq.sv
// Memory sequencer: holds the single outstanding request and the busy
// scoreboard. A start creates a request on the next edge. The acknowledge
// retires it and, for loads, asks the operand bank to fill the destination.
// Assumes start is never raised while pending is high.
module art_mem_seq #(
    parameter int AW   = 18,
    parameter int DW   = 60,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_load,
    input  logic            start_store,
    input  logic [IW-1:0]   start_idx,
    input  logic [AW-1:0]   start_addr,
    input  logic [DW-1:0]   store_data,
    input  logic            mem_ack,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            pending,
    output logic [NREG-1:0] busy_mask,
    output logic            fill_en,
    output logic [IW-1:0]   fill_idx
);
    logic          req_q, we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [IW-1:0] idx_q;
    logic [NREG-1:0] busy_q;
    logic          retire;

    assign retire = req_q && mem_ack;

    // Request register: open on start, close on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
        end else if (retire) begin
            req_q <= 1'b0;
        end else if (start_load || start_store) begin
            req_q   <= 1'b1;
            we_q    <= start_store;
            addr_q  <= start_addr;
            wdata_q <= start_store ? store_data : '0;
            idx_q   <= start_idx;
        end
    end

    // Scoreboard: mark the load destination, clear it on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= '0;
        else if (retire)
            busy_q <= '0;
        else if (start_load)
            busy_q <= NREG'(1) << start_idx;
    end

    assign mem_req   = req_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign pending   = req_q;
    assign busy_mask = busy_q;
    assign fill_en   = retire && !we_q;
    assign fill_idx  = idx_q;

    // A waiting request keeps its fields.
    assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    // At most one operand register is marked busy.
    assert_busy_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_mask));
    // A busy bit exists only while a load request is open.
    assert_busy_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_mask != '0) |-> (mem_req && !mem_we));
    // Store data is taken once and held while the request is open.
    assert_store_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));
endmodule

// File: rtl/addr_trig_regfile.sv
// Top: address, index and operand register files with implicit memory
// traffic. An accepted write to an address register in the load range
// starts a read into the paired operand register. One in the store range
// starts a write of the paired operand register. Triggering writes stall
// while a request is open, and operand writes stall on a busy destination.
// Assumes the memory acknowledges each request exactly once.
module addr_trig_regfile
    import art_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NREG = NUM_REGS,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_file,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    output logic            wr_ready,
    input  logic [1:0]      rd_file,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic [NREG-1:0] busy_mask
);
    file_sel_e wsel, rsel;
    logic      is_load_idx, is_store_idx, trig, stall, accept;
    logic      pending, fill_en;
    logic [IW-1:0] fill_idx;
    logic [NREG-1:0][AW-1:0] a_regs, b_regs;
    logic [NREG-1:0][DW-1:0] x_regs;

    assign wsel = file_sel_e'(wr_file);
    assign rsel = file_sel_e'(rd_file);

    // Decode which address register numbers trigger memory traffic.
    always_comb begin
        is_load_idx  = (int'(wr_idx) >= LOAD_FIRST)  && (int'(wr_idx) <= LOAD_LAST);
        is_store_idx = (int'(wr_idx) >= STORE_FIRST) && (int'(wr_idx) <= STORE_LAST);
        trig         = (wsel == FILE_A) && (is_load_idx || is_store_idx);
    end

    // Stall rules: one open request; no overwrite of a pending load target.
    always_comb begin
        stall = (trig && pending) ||
                ((wsel == FILE_X) && busy_mask[wr_idx]);
    end

    assign wr_ready = !stall;
    assign accept   = wr_en && !stall;

    art_reg_bank #(.W(AW), .N(NREG), .HARD_ZERO0(1'b0)) u_abank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && wsel == FILE_A), .wr_idx(wr_idx), .wr_data(wr_data[AW-1:0]),
        .fill_en(1'b0), .fill_idx('0), .fill_data('0),
        .regs_o(a_regs)
    );

    art_reg_bank #(.W(AW), .N(NREG), .HARD_ZERO0(1'b1)) u_bbank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && wsel == FILE_B), .wr_idx(wr_idx), .wr_data(wr_data[AW-1:0]),
        .fill_en(1'b0), .fill_idx('0), .fill_data('0),
        .regs_o(b_regs)
    );

    art_reg_bank #(.W(DW), .N(NREG), .HARD_ZERO0(1'b0)) u_xbank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && wsel == FILE_X), .wr_idx(wr_idx), .wr_data(wr_data),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(mem_rdata),
        .regs_o(x_regs)
    );

    art_mem_seq #(.AW(AW), .DW(DW), .NREG(NREG)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_load(accept && trig && is_load_idx),
        .start_store(accept && trig && is_store_idx),
        .start_idx(wr_idx), .start_addr(wr_data[AW-1:0]),
        .store_data(x_regs[wr_idx]),
        .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pending(pending), .busy_mask(busy_mask),
        .fill_en(fill_en), .fill_idx(fill_idx)
    );

    // Read mux: zero-extend the narrow files, hide the unused code.
    always_comb begin
        case (rsel)
            FILE_A:  rd_data = DW'(a_regs[rd_idx]);
            FILE_B:  rd_data = DW'(b_regs[rd_idx]);
            FILE_X:  rd_data = x_regs[rd_idx];
            default: rd_data = '0;
        endcase
        rd_valid = !((rsel == FILE_X) && busy_mask[rd_idx]);
    end

    // Scratch address register never opens a request.
    assert_a0_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == FILE_A && wr_idx == '0 && !mem_req) |=> !mem_req);
    // No second trigger is taken while a request is open.
    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && wr_en && trig) |-> !wr_ready);
    // Accepted load trigger shows up as a read request next cycle.
    assert_load_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && trig && is_load_idx) |=> (mem_req && !mem_we));
    // Busy operand register cannot be overwritten by the port.
    assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == FILE_X && busy_mask[wr_idx]) |-> !wr_ready);
endmodule

// File: tb/sim_addr_trig_regfile.sv
module sim_addr_trig_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_file;
    logic [2:0]  wr_idx;
    logic [59:0] wr_data;
    logic        wr_ready;
    logic [1:0]  rd_file;
    logic [2:0]  rd_idx;
    logic [59:0] rd_data;
    logic        rd_valid;
    logic        mem_req, mem_we, mem_ack;
    logic [17:0] mem_addr;
    logic [59:0] mem_wdata, mem_rdata;
    logic [7:0]  busy_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_trig_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_file(wr_file), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_ready(wr_ready),
        .rd_file(rd_file), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy_mask(busy_mask)
    );

    function automatic logic [59:0] mem_word(input logic [17:0] a);
        return {6'h2A, a, ~a, a ^ 18'h0F0F0};
    endfunction

    function automatic logic [59:0] xpat(input int i, input int k);
        return {4'(i), 56'h0123_4567_89AB_CD} ^ {60{k[0]}} ^ (60'(k) << 20);
    endfunction

    task automatic check(input string tag, input logic [59:0] act, input logic [59:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] f, input int i, output logic [59:0] v, output logic ok);
        rd_file = f; rd_idx = 3'(i);
        #1;
        v = rd_data; ok = rd_valid;
    endtask

    // Drive one write for one cycle; returns at the following negedge.
    task automatic wr(input logic [1:0] f, input int i, input logic [59:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_file = f; wr_idx = 3'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack_now(input logic [59:0] d);
        @(negedge clk);
        mem_ack = 1'b1; mem_rdata = d;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=%h exp=%h", 60'd0, 60'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [59:0] v;
        logic        ok;
        logic [17:0] addrs [5];
        addrs[0] = 18'h00000; addrs[1] = 18'h3FFFF; addrs[2] = 18'h15555;
        addrs[3] = 18'h2AAAA; addrs[4] = 18'h1C3E7;

        rst_n = 1'b0; wr_en = 1'b0; wr_file = '0; wr_idx = '0; wr_data = '0;
        rd_file = '0; rd_idx = '0; mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < 8; i++) begin
                rd(2'(f), i, v, ok);
                check("R1 reg zero", v, 60'd0);
            end
        check("R1 req", 60'(mem_req), 60'd0);
        check("R1 busy", 60'(busy_mask), 60'd0);
        check("R1 ready", 60'(wr_ready), 60'd1);

        // R8/R9: index file sweep
        for (int i = 0; i < 8; i++) wr(2'd1, i, xpat(i, 3));
        for (int i = 0; i < 8; i++) begin
            rd(2'd1, i, v, ok);
            if (i == 0) check("R8 B0 zero", v, 60'd0);
            else        check("R9 B readback", v, 60'(xpat(i, 3) & 60'h3FFFF));
        end

        // R9: operand file sweep
        for (int i = 0; i < 8; i++) wr(2'd2, i, xpat(i, 1));
        for (int i = 0; i < 8; i++) begin
            rd(2'd2, i, v, ok);
            check("R9 X readback", v, xpat(i, 1));
        end

        // R11: unused file code
        wr(2'd3, 2, 60'hFFF_FFFF_FFFF_FFFF);
        rd(2'd3, 2, v, ok);
        check("R11 read zero", v, 60'd0);
        rd(2'd2, 2, v, ok);
        check("R11 X2 untouched", v, xpat(2, 1));
        rd(2'd1, 2, v, ok);
        check("R11 B2 untouched", v, 60'(xpat(2, 3) & 60'h3FFFF));

        // R2: scratch register
        foreach (addrs[k]) begin
            wr(2'd0, 0, {42'h1, addrs[k]});
            check("R2 no request", 60'(mem_req), 60'd0);
            rd(2'd0, 0, v, ok);
            check("R2 A0 value", v, 60'(addrs[k]));
        end

        // R3/R4: loads for every load number and address, varied latency
        foreach (addrs[k])
            for (int i = 1; i <= 5; i++) begin
                logic [17:0] a;
                a = addrs[k] ^ 18'(i);
                wr(2'd0, i, 60'(a));
                check("R3 req", 60'(mem_req), 60'd1);
                check("R3 we", 60'(mem_we), 60'd0);
                check("R3 addr", 60'(mem_addr), 60'(a));
                check("R4 busy bit", 60'(busy_mask), 60'(8'd1 << i));
                rd(2'd2, i, v, ok);
                check("R4 rd_valid low", 60'(ok), 60'd0);
                for (int w = 0; w < (i + k) % 3; w++) begin
                    @(negedge clk);
                    check("R3 req held", 60'(mem_req), 60'd1);
                    check("R4 busy held", 60'(busy_mask), 60'(8'd1 << i));
                end
                ack_now(mem_word(a));
                check("R3 req done", 60'(mem_req), 60'd0);
                check("R4 busy clear", 60'(busy_mask), 60'd0);
                rd(2'd2, i, v, ok);
                check("R3 X landed", v, mem_word(a));
                check("R4 rd_valid high", 60'(ok), 60'd1);
                rd(2'd0, i, v, ok);
                check("R3 A holds addr", v, 60'(a));
            end
        // R3: loads reach only their own operand register
        rd(2'd2, 0, v, ok);
        check("R3 X0 untouched", v, xpat(0, 1));
        rd(2'd2, 6, v, ok);
        check("R3 X6 untouched", v, xpat(6, 1));

        // R5/R6: stores
        foreach (addrs[k])
            for (int i = 6; i <= 7; i++) begin
                logic [59:0] d;
                d = xpat(i, k + 5);
                wr(2'd2, i, d);
                wr(2'd0, i, 60'(addrs[k]));
                check("R5 req", 60'(mem_req), 60'd1);
                check("R5 we", 60'(mem_we), 60'd1);
                check("R5 addr", 60'(mem_addr), 60'(addrs[k]));
                check("R5 wdata", mem_wdata, d);
                check("R5 no busy", 60'(busy_mask), 60'd0);
                wr(2'd2, i, ~d);
                check("R6 wdata kept", mem_wdata, d);
                rd(2'd2, i, v, ok);
                check("R6 X updated", v, ~d);
                ack_now(60'd0);
                check("R5 req done", 60'(mem_req), 60'd0);
            end

        // R7/R10: stalls during an open load on A1
        wr(2'd0, 3, 60'h00123);
        ack_now(60'h777);
        wr(2'd0, 1, 60'h00456);
        @(negedge clk);
        wr_en = 1'b1; wr_file = 2'd0; wr_idx = 3'd3; wr_data = 60'h3ABCD;
        #1;
        check("R7 trigger stalled", 60'(wr_ready), 60'd0);
        wr_idx = 3'd7; #1;
        check("R7 store stalled", 60'(wr_ready), 60'd0);
        wr_file = 2'd2; wr_idx = 3'd1; wr_data = 60'h5; #1;
        check("R10 busy X stalled", 60'(wr_ready), 60'd0);
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd0, 3, v, ok);
        check("R7 A3 unchanged", v, 60'h00123);
        rd(2'd0, 7, v, ok);
        check("R7 A7 unchanged", v, 60'(addrs[4]));
        check("R7 one request", 60'(mem_addr), 60'h00456);
        wr(2'd0, 0, 60'h00999);
        rd(2'd0, 0, v, ok);
        check("R7 A0 proceeds", v, 60'h00999);
        wr(2'd1, 4, 60'h00ABC);
        rd(2'd1, 4, v, ok);
        check("R7 B proceeds", v, 60'h00ABC);
        wr(2'd2, 2, 60'h42);
        rd(2'd2, 2, v, ok);
        check("R10 other X proceeds", v, 60'h42);
        ack_now(mem_word(18'h00456));
        rd(2'd2, 1, v, ok);
        check("R10 X1 gets load data", v, mem_word(18'h00456));
        wr(2'd0, 3, 60'h3ABCD);
        check("R7 trigger after retire", 60'(mem_addr), 60'h3ABCD);
        ack_now(60'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule